// File: doc/BRIEF.md
# Packet Page Allocator and Queue Manager

This block owns a small pool of fixed-size packet pages in a buffer memory and hands out page numbers to the transmit and receive paths. It keeps one bit per page to mark which pages are in use. It also keeps three first-in first-out queues of page numbers: pages waiting to be sent, pages whose transmission has finished, and pages holding received frames. Software drives it by writing a command byte, and the 3-bit operation sits in bits 7:5 of that byte. The receive path asks for pages through a separate request line.

A transmit allocation that finds no free page is not dropped. The failure code stays in the result register, and the next page release of any kind completes the allocation automatically. Transmission is modelled as a handshake: the block offers the head of the transmit queue while sending is enabled, and each acknowledge completes that page. A completed page is either freed on the spot or recorded in the done queue. The page data and the framing are handled elsewhere.

Top module: `pkt_page_mgr`

## Requirements
- R1: After reset the allocation result is 0, both queue head outputs read 0x80 (empty), the used-page count is 0, the allocation-done flag is low and no transmit request is raised.
- R2: Operation 1 (allocate for transmit) first sets the result to 0x80 and clears the allocation-done flag. If a page is free, it then claims the lowest-numbered free page, stores that number in the result and sets the allocation-done flag. Operation 0 changes nothing.
- R3: If operation 1 finds every page in use, the result reads 0x80 and the flag stays low. The next release of any page retries the allocation, which stores the freed page number and sets the flag.
- R4: A receive request is granted (rx_alloc_ok high in the same cycle) only when a page is free. It takes the lowest free page and appends it to the receive queue. With every page in use, the request is refused and nothing changes.
- R5: Operation 3 removes the head of the receive queue without freeing its page. A queue head output reads 0x80 whenever its queue is empty.
- R6: Operation 4 frees the page at the head of the receive queue and then removes that entry. On an empty receive queue it has no effect.
- R7: Operation 6 appends the page number input to the transmit queue. When the queue already holds 4 entries, the push is ignored. tx_req is high only while tx_enable is set and the queue is not empty, and tx_page shows the queue head.
- R8: An acknowledge while tx_req is high removes the head page. With auto_release set, that page is freed. Otherwise it is appended to the done queue, provided the done queue holds fewer than 4 entries. An acknowledge while tx_req is low is ignored.
- R9: Operation 7 empties the transmit and done queues and leaves the page map unchanged.
- R10: Operation 2 frees every page, empties all three queues and sets the result to 0 (no retry pending).
- R11: used_count always equals the number of pages marked in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_byte | input | 8 | Command byte; operation in bits 7:5 |
| pkt_num | input | 2 | Page number used by operations 5 and 6 |
| tx_enable | input | 1 | Allows the transmit queue to drain |
| auto_release | input | 1 | Free completed transmit pages instead of queuing them |
| tx_ack | input | 1 | Completes the page offered on tx_page |
| rx_alloc_req | input | 1 | Receive path asks for a page |
| rx_alloc_ok | output | 1 | Receive request granted this cycle |
| rx_page | output | 2 | Page granted to the receive path |
| alloc_result | output | 8 | Transmit allocation result, 0x80 on failure |
| alloc_done | output | 1 | Transmit allocation succeeded |
| done_head | output | 8 | Head of the done queue, 0x80 if empty |
| rx_head | output | 8 | Head of the receive queue, 0x80 if empty |
| used_count | output | 3 | Number of pages in use |
| tx_req | output | 1 | A page is offered for transmission |
| tx_page | output | 2 | Page offered for transmission |

## Verification
Command, acknowledge and receive-request effects all land on one clock edge. The result, the flag, the queue heads and the count are therefore due on the first edge after the stimulus cycle. The bench drives each input on a falling edge and reads those outputs on the next falling edge. Two outputs are combinational: rx_alloc_ok depends on the current request, and tx_req and tx_page depend on tx_enable. The bench reads these a moment after it drives them, inside the same cycle.

// File: rtl/pkt_page_pkg.sv
`timescale 1ns/1ps
package pkt_page_pkg;
    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_TX_ALLOC = 3'd1,
        OP_POOL_CLR = 3'd2,
        OP_RX_POP   = 3'd3,
        OP_RX_FREE  = 3'd4,
        OP_REL_NUM  = 3'd5,
        OP_TX_PUSH  = 3'd6,
        OP_TX_CLR   = 3'd7
    } page_op_e;

    localparam logic [7:0] NO_PAGE = 8'h80;
endpackage

// File: rtl/pkt_ones_count.sv
`timescale 1ns/1ps
module pkt_ones_count #(
    parameter int W  = 4,
    parameter int OW = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits_i,
    output logic [OW-1:0] count_o
);
    always_comb begin
        count_o = '0;
        for (int i = 0; i < W; i++) begin
            count_o = count_o + OW'(bits_i[i]);
        end
    end
endmodule

// File: rtl/pkt_head_fmt.sv
`timescale 1ns/1ps
module pkt_head_fmt #(
    parameter int PW = 2,
    parameter int CW = 3
) (
    input  logic [CW-1:0] fill_i,
    input  logic [PW-1:0] head_i,
    output logic [7:0]    code_o
);
    always_comb begin
        if (fill_i == '0) code_o = pkt_page_pkg::NO_PAGE;
        else              code_o = 8'(head_i);
    end
endmodule

// File: rtl/pkt_page_mgr.sv
`timescale 1ns/1ps
module pkt_page_mgr #(
    parameter int N_PAGES = 4,
    parameter int Q_DEPTH = 4,
    localparam int PW = $clog2(N_PAGES),
    localparam int CW = $clog2(Q_DEPTH + 1),
    localparam int UW = $clog2(N_PAGES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic [7:0]    cmd_byte,
    input  logic [PW-1:0] pkt_num,
    input  logic          tx_enable,
    input  logic          auto_release,
    input  logic          tx_ack,
    input  logic          rx_alloc_req,
    output logic          rx_alloc_ok,
    output logic [PW-1:0] rx_page,
    output logic [7:0]    alloc_result,
    output logic          alloc_done,
    output logic [7:0]    done_head,
    output logic [7:0]    rx_head,
    output logic [UW-1:0] used_count,
    output logic          tx_req,
    output logic [PW-1:0] tx_page
);
    import pkt_page_pkg::*;

    typedef logic [Q_DEPTH-1:0][PW-1:0] queue_t;

    typedef struct packed {
        logic [N_PAGES-1:0] map;
        logic [7:0]         result;
        logic               done;
        queue_t             txq;
        queue_t             dq;
        queue_t             rxq;
        logic [CW-1:0]      txn;
        logic [CW-1:0]      dn;
        logic [CW-1:0]      rxn;
    } state_t;

    state_t   s_d, s_q;
    page_op_e op;
    logic     grant_d;
    logic [PW-1:0] grant_pg_d;

    // Bit PW high means no page is free; low bits hold the lowest free index.
    function automatic logic [PW:0] lowest_free(logic [N_PAGES-1:0] m);
        logic [PW:0] r;
        r = {1'b1, {PW{1'b0}}};
        for (int i = N_PAGES - 1; i >= 0; i--) begin
            if (!m[i]) r = {1'b0, PW'(i)};
        end
        return r;
    endfunction

    function automatic queue_t q_push(queue_t q, logic [CW-1:0] fill, logic [PW-1:0] v);
        queue_t r;
        r = q;
        for (int i = 0; i < Q_DEPTH; i++) begin
            if (CW'(i) == fill) r[i] = v;
        end
        return r;
    endfunction

    function automatic queue_t q_pop(queue_t q);
        queue_t r;
        r = q;
        for (int i = 0; i < Q_DEPTH - 1; i++) r[i] = q[i+1];
        r[Q_DEPTH-1] = '0;
        return r;
    endfunction

    function automatic state_t try_tx(state_t s);
        state_t r;
        logic [PW:0] f;
        r = s;
        f = lowest_free(r.map);
        if (!f[PW]) begin
            r.map[f[PW-1:0]] = 1'b1;
            r.result         = 8'(f[PW-1:0]);
            r.done           = 1'b1;
        end
        return r;
    endfunction

    // Free a page; a pending transmit allocation is retried at once.
    function automatic state_t free_page(state_t s, logic [PW-1:0] pg);
        state_t r;
        r = s;
        r.map[pg] = 1'b0;
        if (r.result == NO_PAGE) r = try_tx(r);
        return r;
    endfunction

    assign op = page_op_e'(cmd_byte[7:5]);

    always_comb begin
        logic [PW:0]   f;
        logic [PW-1:0] done_pg;
        s_d        = s_q;
        grant_d    = 1'b0;
        grant_pg_d = '0;
        f          = '0;
        done_pg    = '0;

        // Command register operation.
        if (cmd_wr) begin
            case (op)
                OP_TX_ALLOC: begin
                    s_d.result = NO_PAGE;
                    s_d.done   = 1'b0;
                    s_d        = try_tx(s_d);
                end
                OP_POOL_CLR: begin
                    s_d.map    = '0;
                    s_d.txn    = '0;
                    s_d.dn     = '0;
                    s_d.rxn    = '0;
                    s_d.result = '0;
                end
                OP_RX_POP: begin
                    if (s_d.rxn != '0) begin
                        s_d.rxq = q_pop(s_d.rxq);
                        s_d.rxn = s_d.rxn - CW'(1);
                    end
                end
                OP_RX_FREE: begin
                    if (s_d.rxn != '0) begin
                        s_d     = free_page(s_d, s_d.rxq[0]);
                        s_d.rxq = q_pop(s_d.rxq);
                        s_d.rxn = s_d.rxn - CW'(1);
                    end
                end
                OP_REL_NUM: s_d = free_page(s_d, pkt_num);
                OP_TX_PUSH: begin
                    if (s_d.txn != CW'(Q_DEPTH)) begin
                        s_d.txq = q_push(s_d.txq, s_d.txn, pkt_num);
                        s_d.txn = s_d.txn + CW'(1);
                    end
                end
                OP_TX_CLR: begin
                    s_d.txn = '0;
                    s_d.dn  = '0;
                end
                default: ;
            endcase
        end

        // Transmit completion handshake.
        if (tx_ack && tx_req && s_d.txn != '0) begin
            done_pg = s_d.txq[0];
            s_d.txq = q_pop(s_d.txq);
            s_d.txn = s_d.txn - CW'(1);
            if (auto_release) begin
                s_d = free_page(s_d, done_pg);
            end else if (s_d.dn != CW'(Q_DEPTH)) begin
                s_d.dq = q_push(s_d.dq, s_d.dn, done_pg);
                s_d.dn = s_d.dn + CW'(1);
            end
        end

        // Receive-side page request.
        if (rx_alloc_req) begin
            f = lowest_free(s_d.map);
            if (!f[PW] && s_d.rxn != CW'(Q_DEPTH)) begin
                grant_d    = 1'b1;
                grant_pg_d = f[PW-1:0];
                s_d.map[f[PW-1:0]] = 1'b1;
                s_d.rxq = q_push(s_d.rxq, s_d.rxn, f[PW-1:0]);
                s_d.rxn = s_d.rxn + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rx_alloc_ok  = grant_d;
    assign rx_page      = grant_pg_d;
    assign alloc_result = s_q.result;
    assign alloc_done   = s_q.done;
    assign tx_req       = tx_enable && (s_q.txn != '0);
    assign tx_page      = s_q.txq[0];

    pkt_head_fmt #(.PW(PW), .CW(CW)) u_done_head (
        .fill_i(s_q.dn), .head_i(s_q.dq[0]), .code_o(done_head)
    );
    pkt_head_fmt #(.PW(PW), .CW(CW)) u_rx_head (
        .fill_i(s_q.rxn), .head_i(s_q.rxq[0]), .code_o(rx_head)
    );
    pkt_ones_count #(.W(N_PAGES), .OW(UW)) u_count (
        .bits_i(s_q.map), .count_o(used_count)
    );
endmodule

// File: rtl/pkt_page_mgr_chk.sv
`timescale 1ns/1ps
module pkt_page_mgr_chk #(
    parameter int N_PAGES = 4,
    parameter int UW      = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_wr,
    input logic [7:0]    cmd_byte,
    input logic          tx_enable,
    input logic          tx_ack,
    input logic          rx_alloc_req,
    input logic          rx_alloc_ok,
    input logic [7:0]    alloc_result,
    input logic          alloc_done,
    input logic [7:0]    done_head,
    input logic [7:0]    rx_head,
    input logic [UW-1:0] used_count,
    input logic          tx_req
);
    AST_ALLOC_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && cmd_byte[7:5] == 3'd1 && used_count < UW'(N_PAGES)
        |=> alloc_done && !alloc_result[7]); // R2

    AST_ALLOC_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && cmd_byte[7:5] == 3'd1 && used_count == UW'(N_PAGES) && !tx_ack
        |=> alloc_result == 8'h80 && !alloc_done); // R3

    AST_RX_REFUSED_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_alloc_req && !cmd_wr && !tx_ack && used_count == UW'(N_PAGES)
        |-> !rx_alloc_ok); // R4

    AST_TX_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> tx_enable); // R7

    AST_TX_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && cmd_byte[7:5] == 3'd7
        |=> done_head == 8'h80 && !tx_req); // R9

    AST_POOL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && cmd_byte[7:5] == 3'd2 && !rx_alloc_req
        |=> used_count == '0 && rx_head == 8'h80 && done_head == 8'h80
            && alloc_result == 8'h00); // R10

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        used_count <= UW'(N_PAGES)); // R11
endmodule

bind pkt_page_mgr pkt_page_mgr_chk #(.N_PAGES(N_PAGES), .UW(UW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
    .tx_enable(tx_enable), .tx_ack(tx_ack), .rx_alloc_req(rx_alloc_req),
    .rx_alloc_ok(rx_alloc_ok), .alloc_result(alloc_result),
    .alloc_done(alloc_done), .done_head(done_head), .rx_head(rx_head),
    .used_count(used_count), .tx_req(tx_req)
);

// File: tb/pkt_page_mgr_test.sv
`timescale 1ns/1ps
module pkt_page_mgr_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [7:0] cmd_byte = '0;
    logic [1:0] pkt_num = '0;
    logic       tx_enable = 1'b0;
    logic       auto_release = 1'b0;
    logic       tx_ack = 1'b0;
    logic       rx_alloc_req = 1'b0;
    logic       rx_alloc_ok;
    logic [1:0] rx_page;
    logic [7:0] alloc_result;
    logic       alloc_done;
    logic [7:0] done_head;
    logic [7:0] rx_head;
    logic [2:0] used_count;
    logic       tx_req;
    logic [1:0] tx_page;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    pkt_page_mgr uut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
        .pkt_num(pkt_num), .tx_enable(tx_enable), .auto_release(auto_release),
        .tx_ack(tx_ack), .rx_alloc_req(rx_alloc_req), .rx_alloc_ok(rx_alloc_ok),
        .rx_page(rx_page), .alloc_result(alloc_result), .alloc_done(alloc_done),
        .done_head(done_head), .rx_head(rx_head), .used_count(used_count),
        .tx_req(tx_req), .tx_page(tx_page)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Issue one command; outputs are read on the following falling edge.
    task automatic do_cmd(logic [2:0] op, logic [1:0] pn);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_byte = {op, 5'b0}; pkt_num = pn;
        @(negedge clk);
        cmd_wr = 1'b0; cmd_byte = '0;
    endtask

    task automatic rx_request(logic exp_ok, logic [1:0] exp_pg, string req);
        @(negedge clk);
        rx_alloc_req = 1'b1;
        #1;
        check(req, rx_alloc_ok, exp_ok);
        if (exp_ok) check(req, rx_page, exp_pg);
        @(negedge clk);
        rx_alloc_req = 1'b0;
    endtask

    task automatic ack_once;
        @(negedge clk);
        tx_ack = 1'b1;
        @(negedge clk);
        tx_ack = 1'b0;
    endtask

    task automatic t_reset_state;
        check("R1 result", alloc_result, 8'h00);
        check("R1 done_head", done_head, 8'h80);
        check("R1 rx_head", rx_head, 8'h80);
        check("R1 count", used_count, 0);
        check("R1 flag", alloc_done, 0);
        check("R1 tx_req", tx_req, 0);
    endtask

    task automatic t_alloc;
        do_cmd(3'd1, 2'd0);
        check("R2 first page", alloc_result, 8'h00);
        check("R2 flag", alloc_done, 1);
        check("R11 count", used_count, 1);
        do_cmd(3'd0, 2'd0);
        check("R2 nop result", alloc_result, 8'h00);
        check("R2 nop count", used_count, 1);
        do_cmd(3'd1, 2'd0);
        check("R2 second page", alloc_result, 8'h01);
        check("R11 count two", used_count, 2);
        do_cmd(3'd2, 2'd0);
        check("R10 count", used_count, 0);
        check("R10 result", alloc_result, 8'h00);
    endtask

    task automatic t_pending;
        for (int i = 0; i < 4; i++) do_cmd(3'd1, 2'd0);
        check("R2 last page", alloc_result, 8'h03);
        check("R11 full count", used_count, 4);
        do_cmd(3'd1, 2'd0);
        check("R3 fail code", alloc_result, 8'h80);
        check("R3 flag low", alloc_done, 0);
        do_cmd(3'd5, 2'd2);
        check("R3 retry page", alloc_result, 8'h02);
        check("R3 retry flag", alloc_done, 1);
        check("R3 count", used_count, 4);
        do_cmd(3'd2, 2'd0);
        check("R10 after full", used_count, 0);
    endtask

    task automatic t_receive;
        rx_request(1'b1, 2'd0, "R4 grant 0");
        rx_request(1'b1, 2'd1, "R4 grant 1");
        check("R4 rx head", rx_head, 8'h00);
        check("R11 rx count", used_count, 2);
        do_cmd(3'd3, 2'd0);
        check("R5 pop head", rx_head, 8'h01);
        check("R5 no release", used_count, 2);
        do_cmd(3'd4, 2'd0);
        check("R6 empty head", rx_head, 8'h80);
        check("R6 released", used_count, 1);
        do_cmd(3'd4, 2'd0);
        check("R6 empty no effect", used_count, 1);
        rx_request(1'b1, 2'd1, "R4 grant 1 again");
        rx_request(1'b1, 2'd2, "R4 grant 2");
        rx_request(1'b1, 2'd3, "R4 grant 3");
        check("R4 full", used_count, 4);
        rx_request(1'b0, 2'd0, "R4 refused");
        check("R4 refused count", used_count, 4);
        check("R4 refused head", rx_head, 8'h01);
        do_cmd(3'd2, 2'd0);
        check("R10 rx head", rx_head, 8'h80);
    endtask

    task automatic t_transmit;
        tx_enable = 1'b0; auto_release = 1'b0;
        do_cmd(3'd1, 2'd0);
        do_cmd(3'd1, 2'd0);
        do_cmd(3'd6, 2'd1);
        do_cmd(3'd6, 2'd0);
        check("R7 gated", tx_req, 0);
        tx_enable = 1'b1;
        #1;
        check("R7 req", tx_req, 1);
        check("R7 page", tx_page, 2'd1);
        ack_once();
        check("R8 done head", done_head, 8'h01);
        check("R8 next page", tx_page, 2'd0);
        auto_release = 1'b1;
        ack_once();
        check("R8 auto freed", used_count, 1);
        check("R8 done kept", done_head, 8'h01);
        check("R7 drained", tx_req, 0);
        auto_release = 1'b0;
        tx_enable = 1'b0;
        for (int i = 0; i < 5; i++) do_cmd(3'd6, 2'd1);
        tx_enable = 1'b1;
        for (int i = 0; i < 4; i++) begin
            #1;
            check("R7 queued entry", tx_req, 1);
            ack_once();
        end
        #1;
        check("R7 full push dropped", tx_req, 0);
        ack_once();
        check("R8 idle ack head", done_head, 8'h01);
        check("R8 idle ack count", used_count, 1);
        do_cmd(3'd7, 2'd0);
        check("R9 done cleared", done_head, 8'h80);
        check("R9 map kept", used_count, 1);
        tx_enable = 1'b0;
        do_cmd(3'd2, 2'd0);
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_alloc();
        t_pending();
        t_receive();
        t_transmit();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule